// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block takes up to 60 maskable request lines, each with its own 4-bit priority. It hands a processor stub the vector number of the most urgent pending request. A request pulse marks the line as pending, and software may also set or clear that mark. Enabled pending lines are arbitrated every cycle. When the winner outranks the current execution priority, an entry phase starts, and at its end the vector becomes the active handler.

Preempted handlers stay on a stack of active priorities. There is one stack slot per priority level, so nesting is at most 16 deep. While an entry phase is in progress, a request that arrives with a more urgent priority takes over the vector being entered. When the handler exits, a pending request that outranks the context underneath is entered at once in a shorter tail-chained entry, with no return to the context underneath in between.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After synchronous active-low reset: `nest_depth` is 0, `exec_prio` is 16 (thread level, no handler active), `in_entry` and `hdl_start` are 0, and all pending and active bits are 0.
- R2: Among lines that are both pending and enabled, the smaller priority value wins. On equal values the lower line number wins. A line whose enable is 0 is never entered, but it stays pending.
- R3: A line's pending bit is set by a one-cycle `irq_req` pulse or by `pend_set`. It is cleared by `pend_clr`, and a clear wins over a set in the same cycle. It is also cleared when the line's entry completes. `pend_o` shows the pending bits.
- R4: An entry starts only when the winner's priority value is strictly smaller than `exec_prio`. An equal value never preempts.
- R5: A normal entry keeps `in_entry` high for 12 cycles. One cycle of `hdl_start` follows. At that point `cur_vec` holds the vector, `nest_depth` has risen by one, `exec_prio` holds the vector's priority, and its `active_o` bit is set.
- R6: During every entry cycle but the last, a winner with a strictly smaller priority value than the one being entered replaces `entry_vec`. The phase keeps its original length. The displaced line stays pending.
- R7: An `hdl_exit` pulse while a handler runs pops the top entry. `nest_depth` drops by one, the popped line's active bit clears, and `exec_prio` returns to the entry underneath (16 when the stack is empty). An exit is ignored when the depth is 0 or during an entry phase.
- R8: On an exit, if the winner's value is strictly smaller than the priority underneath the popped entry, a tail-chained entry starts at once. It lasts 6 cycles with `entry_tail` high. Otherwise the popped-to context resumes with no entry.
- R9: Nesting reaches 16 levels, one per priority value, and unwinds level by level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 60 | Request pulses, one per line |
| irq_en | input | 60 | Enable per line |
| irq_prio | input | 240 | 4-bit priority per line, line n at bits 4n+3..4n |
| pend_set | input | 60 | Software set of pending bits |
| pend_clr | input | 60 | Software clear of pending bits |
| hdl_exit | input | 1 | Handler exit pulse from the processor stub |
| in_entry | output | 1 | Entry phase in progress |
| entry_tail | output | 1 | Current entry is tail-chained |
| entry_vec | output | 6 | Vector being entered |
| hdl_start | output | 1 | One-cycle pulse: handler for `cur_vec` starts |
| cur_vec | output | 6 | Vector of the running handler |
| exec_prio | output | 5 | Current execution priority, 16 at thread level |
| nest_depth | output | 5 | Number of active handlers |
| pend_o | output | 60 | Pending bits |
| active_o | output | 60 | Active bits |

## Verification
The bench targets equal-priority requests during a running handler. A design that compared with less-or-equal would nest them and show a depth of 2. It takes a late arrival in the middle of an entry phase, which catches a design that keeps the first vector, restarts the 12-cycle count, or drops the displaced request. Exits are tested both where the pending request outranks the context underneath and where it only ties with it. A design that returns before re-entering, chains on a tie, or uses the normal entry length for a chain shows up in the vector, the entry length and the `entry_tail` flag. Ties and a fully filled 16-level stack expose wrong tie-breaking and off-by-one depth handling.

// File: rtl/irq_nest_pkg.sv
// Shared types for the nested interrupt controller.
package irq_nest_pkg;
    typedef enum logic {
        CTL_RUN   = 1'b0,
        CTL_ENTRY = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/irq_pend_bank.sv
// Pending-bit bank: one bit per line, set by hardware pulses or software,
// cleared by software or when the line is taken.
// Assumes take_clr is one-hot or zero. A clear wins over a set in the same cycle.
module irq_pend_bank #(
    parameter int NUM_IRQ = 60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] hw_set,
    input  logic [NUM_IRQ-1:0] sw_set,
    input  logic [NUM_IRQ-1:0] sw_clr,
    input  logic [NUM_IRQ-1:0] take_clr,
    output logic [NUM_IRQ-1:0] pend_q
);
    // Update pending bits; clears dominate sets.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | hw_set | sw_set) & ~(sw_clr | take_clr);
    end

    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|take_clr) |=> ((pend_q & $past(take_clr)) == '0)); // R3
    AST_SWCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_clr) |=> ((pend_q & $past(sw_clr)) == '0)); // R3
endmodule

// File: rtl/irq_prio_arb.sv
// Priority arbiter: picks the pending, enabled line with the smallest
// priority value; ties go to the lower line number. Purely combinational.
module irq_prio_arb #(
    parameter int NUM_IRQ = 60,
    parameter int PRIO_W  = 4,
    localparam int VEC_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]        pend,
    input  logic [NUM_IRQ-1:0]        en,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic                      hit,
    output logic [VEC_W-1:0]          win_id,
    output logic [PRIO_W-1:0]         win_prio
);
    // Linear scan from line 0 upward; strict compare keeps the lower index on ties.
    always_comb begin
        hit      = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend[i] && en[i] &&
                (!hit || prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
                hit      = 1'b1;
                win_id   = VEC_W'(i);
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_act_stack.sv
// Stack of active handlers (vector and priority), one slot per priority level.
// Provides the top priority and the priority just below it, both widened by one
// bit so that the value 2**PRIO_W stands for thread level (empty).
// Assumes push and pop never coincide and push only with a strictly higher priority.
module irq_act_stack #(
    parameter int VEC_W  = 6,
    parameter int PRIO_W = 4,
    localparam int DEPTH = 1 << PRIO_W,
    localparam int IDX_W = PRIO_W,
    localparam int DW    = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [VEC_W-1:0]  push_vec,
    input  logic [PRIO_W-1:0] push_prio,
    output logic [DW-1:0]     depth,
    output logic [VEC_W-1:0]  top_vec,
    output logic [DW-1:0]     top_prio,
    output logic [DW-1:0]     under_prio
);
    localparam logic [DW-1:0] THREAD = DW'(DEPTH);

    logic [VEC_W-1:0]  vec_mem  [DEPTH];
    logic [PRIO_W-1:0] prio_mem [DEPTH];
    logic [DW-1:0]     depth_q;
    logic [DW-1:0]     top_idx;
    logic [DW-1:0]     und_idx;

    assign top_idx = depth_q - DW'(1);
    assign und_idx = depth_q - DW'(2);

    // Depth counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    depth_q <= '0;
        else if (push) depth_q <= depth_q + DW'(1);
        else if (pop)  depth_q <= depth_q - DW'(1);
    end

    // Slot storage; written only on push, needs no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            vec_mem[depth_q[IDX_W-1:0]]  <= push_vec;
            prio_mem[depth_q[IDX_W-1:0]] <= push_prio;
        end
    end

    // Read the top and the entry beneath it.
    always_comb begin
        top_vec    = (depth_q == '0) ? '0 : vec_mem[top_idx[IDX_W-1:0]];
        top_prio   = (depth_q == '0) ? THREAD : {1'b0, prio_mem[top_idx[IDX_W-1:0]]};
        under_prio = (depth_q < DW'(2)) ? THREAD : {1'b0, prio_mem[und_idx[IDX_W-1:0]]};
    end

    assign depth = depth_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> depth_q < THREAD); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> depth_q != '0); // R7
    AST_PUSH_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> {1'b0, push_prio} < top_prio); // R4
    AST_POP_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> top_prio == $past(under_prio)); // R7
endmodule

// File: rtl/irq_nest_ctrl.sv
// Nested interrupt controller top. It arbitrates pending lines, runs a fixed-length
// entry phase with late-arrival vector replacement, pushes the taken handler onto
// the active stack, and on exit either resumes or tail-chains into a pending line.
// Assumes hdl_exit is a single-cycle pulse from the processor stub.
module irq_nest_ctrl #(
    parameter int NUM_IRQ   = 60,
    parameter int PRIO_W    = 4,
    parameter int ENTRY_CYC = 12,
    parameter int TAIL_CYC  = 6,
    localparam int VEC_W    = $clog2(NUM_IRQ),
    localparam int EP_W     = PRIO_W + 1,
    localparam int CNT_W    = $clog2(ENTRY_CYC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        irq_req,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [NUM_IRQ-1:0]        pend_set,
    input  logic [NUM_IRQ-1:0]        pend_clr,
    input  logic                      hdl_exit,
    output logic                      in_entry,
    output logic                      entry_tail,
    output logic [VEC_W-1:0]          entry_vec,
    output logic                      hdl_start,
    output logic [VEC_W-1:0]          cur_vec,
    output logic [EP_W-1:0]           exec_prio,
    output logic [EP_W-1:0]           nest_depth,
    output logic [NUM_IRQ-1:0]        pend_o,
    output logic [NUM_IRQ-1:0]        active_o
);
    import irq_nest_pkg::*;

    localparam logic [NUM_IRQ-1:0] ONE = NUM_IRQ'(1);

    ctl_state_e         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [VEC_W-1:0]   ent_vec_q;
    logic [PRIO_W-1:0]  ent_prio_q;
    logic               ent_tail_q;
    logic               start_q;
    logic [NUM_IRQ-1:0] active_q;

    logic               hit;
    logic [VEC_W-1:0]   win_id;
    logic [PRIO_W-1:0]  win_prio;
    logic [EP_W-1:0]    depth;
    logic [VEC_W-1:0]   top_vec;
    logic [EP_W-1:0]    top_prio;
    logic [EP_W-1:0]    under_prio;
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] take_clr;

    logic preempt, late, exit_ok, chain, commit;

    irq_pend_bank #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk(clk), .rst_n(rst_n), .hw_set(irq_req), .sw_set(pend_set),
        .sw_clr(pend_clr), .take_clr(take_clr), .pend_q(pend_q)
    );

    irq_prio_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
        .pend(pend_q), .en(irq_en), .prio_flat(irq_prio),
        .hit(hit), .win_id(win_id), .win_prio(win_prio)
    );

    irq_act_stack #(.VEC_W(VEC_W), .PRIO_W(PRIO_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(commit), .pop(exit_ok),
        .push_vec(ent_vec_q), .push_prio(ent_prio_q), .depth(depth),
        .top_vec(top_vec), .top_prio(top_prio), .under_prio(under_prio)
    );

    // Decision terms for the control FSM.
    always_comb begin
        commit   = (state_q == CTL_ENTRY) && (cnt_q == '0);
        late     = (state_q == CTL_ENTRY) && (cnt_q != '0) && hit && (win_prio < ent_prio_q);
        exit_ok  = (state_q == CTL_RUN) && hdl_exit && (depth != '0);
        chain    = hit && ({1'b0, win_prio} < under_prio);
        preempt  = hit && ({1'b0, win_prio} < top_prio);
        take_clr = commit ? (ONE << ent_vec_q) : '0;
    end

    // Control FSM: run/exit/preempt decisions and the entry-phase countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= CTL_RUN;
            cnt_q      <= '0;
            ent_vec_q  <= '0;
            ent_prio_q <= '0;
            ent_tail_q <= 1'b0;
        end else if (state_q == CTL_RUN) begin
            if (exit_ok ? chain : preempt) begin
                state_q    <= CTL_ENTRY;
                cnt_q      <= exit_ok ? CNT_W'(TAIL_CYC - 1) : CNT_W'(ENTRY_CYC - 1);
                ent_tail_q <= exit_ok;
                ent_vec_q  <= win_id;
                ent_prio_q <= win_prio;
            end
        end else if (commit) begin
            state_q    <= CTL_RUN;
            ent_tail_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (late) begin
                ent_vec_q  <= win_id;
                ent_prio_q <= win_prio;
            end
        end
    end

    // Active bits and the handler-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            start_q  <= 1'b0;
        end else begin
            start_q <= commit;
            if (commit)       active_q <= active_q | (ONE << ent_vec_q);
            else if (exit_ok) active_q <= active_q & ~(ONE << top_vec);
        end
    end

    assign in_entry   = (state_q == CTL_ENTRY);
    assign entry_tail = in_entry && ent_tail_q;
    assign entry_vec  = ent_vec_q;
    assign hdl_start  = start_q;
    assign cur_vec    = top_vec;
    assign exec_prio  = top_prio;
    assign nest_depth = depth;
    assign pend_o     = pend_q;
    assign active_o   = active_q;

    AST_ENTRY_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
        in_entry |-> {1'b0, ent_prio_q} < exec_prio); // R4
    AST_LATE_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_entry && $past(in_entry) && entry_vec != $past(entry_vec))
        |-> ent_prio_q < $past(ent_prio_q)); // R6
    AST_START_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_start |-> (nest_depth == $past(nest_depth) + EP_W'(1)) && active_o[cur_vec]); // R5
    AST_TAKEN_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_start |-> !pend_o[cur_vec]); // R3
    AST_IDLE_EXIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (hdl_exit && !in_entry && nest_depth == '0) |=> nest_depth == '0); // R7
    AST_TAIL_ONLY_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_tail) |-> $past(hdl_exit)); // R8
endmodule

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;
    localparam int N = 60;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   irq_req = '0;
    logic [N-1:0]   irq_en = '1;
    logic [N*4-1:0] irq_prio = '1;
    logic [N-1:0]   pend_set = '0;
    logic [N-1:0]   pend_clr = '0;
    logic           hdl_exit = 1'b0;
    logic           in_entry, entry_tail, hdl_start;
    logic [5:0]     entry_vec, cur_vec;
    logic [4:0]     exec_prio, nest_depth;
    logic [N-1:0]   pend_o, active_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    irq_nest_ctrl i_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .irq_prio(irq_prio), .pend_set(pend_set), .pend_clr(pend_clr),
        .hdl_exit(hdl_exit), .in_entry(in_entry), .entry_tail(entry_tail),
        .entry_vec(entry_vec), .hdl_start(hdl_start), .cur_vec(cur_vec),
        .exec_prio(exec_prio), .nest_depth(nest_depth), .pend_o(pend_o),
        .active_o(active_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_req(input int id);
        @(negedge clk);
        irq_req[id] = 1'b1;
        @(posedge clk);
        #1 irq_req[id] = 1'b0;
    endtask

    task automatic do_exit();
        @(negedge clk);
        hdl_exit = 1'b1;
        @(posedge clk);
        #1 hdl_exit = 1'b0;
    endtask

    // Count entry cycles at negedges until the start pulse (or a timeout).
    task automatic wait_start(output int vec, output int ncyc, output bit tail, output bit ok);
        ncyc = 0; tail = 0; ok = 0; vec = -1;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (in_entry) begin
                ncyc++;
                if (entry_tail) tail = 1;
            end
            if (hdl_start) begin
                ok = 1; vec = int'(cur_vec);
                break;
            end
        end
    endtask

    task automatic no_entry_for(input int n, input string req);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (in_entry) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    task automatic take(input int exp_vec, input int exp_cyc, input bit exp_tail, input string req);
        int v, c; bit t, ok;
        wait_start(v, c, t, ok);
        check(ok && v == exp_vec, req, v, exp_vec);
        check(c == exp_cyc, req, c, exp_cyc);
        check(t == exp_tail, req, int'(t), int'(exp_tail));
    endtask

    task automatic t_reset();
        check(nest_depth == 0 && !in_entry && !hdl_start, "R1", int'(nest_depth), 0);
        check(exec_prio == 16, "R1", int'(exec_prio), 16);
        check(pend_o == '0 && active_o == '0, "R1", int'(|pend_o), 0);
    endtask

    task automatic t_basic();
        irq_prio[3*4 +: 4] = 4'd5;
        pulse_req(3);
        take(3, 12, 0, "R5");
        check(nest_depth == 1 && exec_prio == 5, "R5", int'(exec_prio), 5);
        check(active_o[3] && !pend_o[3], "R3", int'(pend_o[3]), 0);
        do_exit();
        @(negedge clk);
        check(nest_depth == 0 && exec_prio == 16 && !active_o[3], "R7", int'(nest_depth), 0);
    endtask

    task automatic t_tie_and_chain();
        irq_prio[4*4 +: 4] = 4'd6;
        irq_prio[10*4 +: 4] = 4'd6;
        @(negedge clk);
        irq_req[4] = 1; irq_req[10] = 1;
        @(posedge clk);
        #1 irq_req[4] = 0; irq_req[10] = 0;
        take(4, 12, 0, "R2 tie");
        do_exit();
        take(10, 6, 1, "R8 chain");
        do_exit();
        no_entry_for(3, "R8 idle");
    endtask

    task automatic t_order();
        irq_prio[30*4 +: 4] = 4'd9;
        irq_prio[31*4 +: 4] = 4'd2;
        @(negedge clk);
        irq_req[30] = 1; irq_req[31] = 1;
        @(posedge clk);
        #1 irq_req[30] = 0; irq_req[31] = 0;
        take(31, 12, 0, "R2 order");
        do_exit();
        take(30, 6, 1, "R8 chain");
        do_exit();
    endtask

    task automatic t_disable_sw();
        irq_prio[40*4 +: 4] = 4'd1;
        irq_en[40] = 0;
        pulse_req(40);
        no_entry_for(20, "R2 disabled");
        check(pend_o[40] == 1, "R2", int'(pend_o[40]), 1);
        @(negedge clk); pend_clr[40] = 1;
        @(negedge clk); pend_clr[40] = 0;
        check(pend_o[40] == 0, "R3 swclr", int'(pend_o[40]), 0);
        irq_en[40] = 1;
        no_entry_for(5, "R3 cleared");
        @(negedge clk); pend_set[40] = 1; pend_clr[40] = 1;
        @(negedge clk); pend_set[40] = 0; pend_clr[40] = 0;
        check(pend_o[40] == 0, "R3 clr wins", int'(pend_o[40]), 0);
        @(negedge clk); pend_set[40] = 1;
        @(posedge clk);
        #1 pend_set[40] = 0;
        take(40, 12, 0, "R3 swset");
        do_exit();
    endtask

    task automatic t_preempt();
        irq_prio[5*4 +: 4] = 4'd8;
        irq_prio[7*4 +: 4] = 4'd8;
        irq_prio[9*4 +: 4] = 4'd3;
        pulse_req(5);
        take(5, 12, 0, "R5");
        pulse_req(7);
        no_entry_for(20, "R4 equal");
        check(nest_depth == 1 && pend_o[7], "R4", int'(nest_depth), 1);
        pulse_req(9);
        take(9, 12, 0, "R4 preempt");
        check(nest_depth == 2 && exec_prio == 3, "R4", int'(exec_prio), 3);
        check(active_o[5] && active_o[9], "R4", int'(active_o[5]), 1);
        do_exit();
        no_entry_for(4, "R8 no chain on tie");
        check(nest_depth == 1 && cur_vec == 5 && exec_prio == 8, "R7", int'(cur_vec), 5);
        do_exit();
        take(7, 6, 1, "R8 chain");
        do_exit();
        @(negedge clk);
        check(nest_depth == 0, "R7", int'(nest_depth), 0);
    endtask

    task automatic t_late();
        int pre = 0;
        int v, c; bit t, ok;
        irq_prio[5*4 +: 4] = 4'd8;
        irq_prio[20*4 +: 4] = 4'd2;
        pulse_req(5);
        while (pre < 3) begin
            @(negedge clk);
            if (in_entry) pre++;
        end
        check(entry_vec == 5, "R6 before", int'(entry_vec), 5);
        irq_req[20] = 1;
        @(posedge clk);
        #1 irq_req[20] = 0;
        wait_start(v, c, t, ok);
        check(ok && v == 20, "R6 late vec", v, 20);
        check(pre + c == 12, "R6 length", pre + c, 12);
        check(pend_o[5] == 1 && nest_depth == 1, "R6 displaced", int'(pend_o[5]), 1);
        do_exit();
        take(5, 6, 1, "R8 after late");
        do_exit();
    endtask

    task automatic t_idle_exit();
        do_exit();
        @(negedge clk);
        check(nest_depth == 0 && exec_prio == 16 && !in_entry, "R7 idle exit", int'(nest_depth), 0);
    endtask

    task automatic t_deep();
        for (int i = 0; i < 16; i++) irq_prio[i*4 +: 4] = 4'(15 - i);
        for (int i = 0; i < 16; i++) begin
            pulse_req(i);
            take(i, 12, 0, "R9 nest");
        end
        check(nest_depth == 16 && exec_prio == 0, "R9 full", int'(nest_depth), 16);
        for (int i = 15; i >= 0; i--) begin
            check(cur_vec == 6'(i), "R9 unwind", int'(cur_vec), i);
            do_exit();
            @(negedge clk);
            check(nest_depth == 5'(i) && !in_entry, "R9 depth", int'(nest_depth), i);
        end
        check(exec_prio == 16 && active_o == '0, "R9 empty", int'(exec_prio), 16);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_tie_and_chain();
        t_order();
        t_disable_sw();
        t_preempt();
        t_late();
        t_idle_exit();
        t_deep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule